// File: doc/BRIEF.md
# Four-Channel DMA Bus Priority Arbiter

This block decides which of four DMA channels owns the memory bus for the next transfer. Each channel raises one bit of a request vector. A separate strobe marks the start of an arbitration cycle. On that strobe the block samples the requests and registers a one-hot grant together with a grant-valid flag. The grant then stays frozen until the next strobe, so it is steady for the whole transfer.

A runtime mode input picks one of two ranking policies. In fixed mode the lowest-numbered requesting channel always wins. In rotating mode the ranking is always a cyclic shift of the ascending channel order. After each grant the ranking shifts so that the channel just served falls to the bottom. A held pointer names the channel at the top of the ranking. The pointer moves only when a rotating-mode grant is actually issued.

Bus handshaking and transfer counting belong to the surrounding controller. The arbiter only chooses which channel is served.

Top module: `dma_prio_arb`

## Requirements
- R1: While rst_ni is low, gnt_o is 0 and gnt_valid_o is 0. After reset the rotating pointer is 0, so a first rotating-mode strobe with all four channels requesting grants channel 0 (gnt_o = 4'b0001).
- R2: A strobe sampled with req_i = 0 clears gnt_o to 0 and gnt_valid_o to 0 at the following clock edge, and leaves the rotating pointer unchanged.
- R3: With rot_mode_i = 0, a strobe grants the lowest-numbered requesting channel: bit 0 beats bit 1, bit 1 beats bit 2, and bit 2 beats bit 3.
- R4: With rot_mode_i = 1, a strobe searches upward from the pointer channel, wrapping from 3 to 0, and grants the first requesting channel found.
- R5: A rotating-mode grant to channel k sets the pointer to (k+1) mod 4, so channel k is ranked lowest at the next strobe.
- R6: The pointer does not change on cycles without a strobe, on strobes with no request, or on fixed-mode grants.
- R7: While arb_strobe_i is low at a clock edge, gnt_o and gnt_valid_o hold their values, whatever req_i and rot_mode_i do.
- R8: gnt_o has at most one bit set, and gnt_valid_o is 1 exactly when gnt_o is nonzero.
- R9: A strobe with any request set yields, one edge later, a valid grant to a channel whose request bit was 1 at that strobe.
- R10: rot_mode_i is sampled at each strobe. After returning to rotating mode, the search resumes from the pointer value left by the last rotating grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-channel bus request, bit n = channel n |
| rot_mode_i | input | 1 | 0 = fixed priority, 1 = rotating priority |
| arb_strobe_i | input | 1 | Arbitration cycle: sample requests and update the grant |
| gnt_o | output | 4 | One-hot grant, held between strobes |
| gnt_valid_o | output | 1 | A channel currently holds the grant |

## Verification
Two things can happen in the same strobe cycle: the grant choice, and the pointer advance that choice causes. The grant must use the old pointer, and the new pointer must apply only to the next strobe. The bench provokes this with back-to-back strobes under full and partial requests, including a wrap from channel 3 to channel 0. It also strobes while changing the mode between consecutive strobes. A behavioural reference model computes each expected grant, and every clock the DUT's grant is compared against it. A wrong pointer therefore shows up as a wrong winner on the following strobe.

// File: rtl/dma_prio_arb_pkg.sv
package dma_prio_arb_pkg;
  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/dma_prio_pick.sv
// Combinational search: first set request at or above base_i, wrapping.
module dma_prio_pick #(
  parameter int N_CH  = 4,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0]  req_i,
  input  logic [IDX_W-1:0] base_i,
  output logic [N_CH-1:0]  onehot_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    found_o  = 1'b0;
    for (int k = 0; k < N_CH; k++) begin
      int             c;
      logic [IDX_W-1:0] cv;
      c = int'(base_i) + k;
      if (c >= N_CH) c = c - N_CH;
      cv = c[IDX_W-1:0];
      if (!found_o && req_i[cv]) begin
        found_o      = 1'b1;
        idx_o        = cv;
        onehot_o[cv] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_ptr.sv
// Rotation pointer: channel currently ranked highest in rotating mode.
module dma_prio_ptr #(
  parameter int N_CH  = 4,
  parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (idx_i == LAST) ? '0 : idx_i + 1'b1;
  end
endmodule

// File: rtl/dma_prio_gnt_reg.sv
// Grant holding register, loaded only on the arbitration strobe.
module dma_prio_gnt_reg #(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [N_CH-1:0] gnt_d_i,
  output logic [N_CH-1:0] gnt_o,
  output logic            valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_o   <= '0;
      valid_o <= 1'b0;
    end else if (load_i) begin
      gnt_o   <= gnt_d_i;
      valid_o <= |gnt_d_i;
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_prio_arb_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic            rot_mode_i,
  input  logic            arb_strobe_i,
  output logic [N_CH-1:0] gnt_o,
  output logic            gnt_valid_o
);
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  prio_mode_e       mode;
  logic [IDX_W-1:0] ptr_q;
  logic [N_CH-1:0]  oh_fix, oh_rot, gnt_d;
  logic [IDX_W-1:0] idx_fix, idx_rot;
  logic             fnd_fix, fnd_rot;
  logic             adv;

  assign mode = prio_mode_e'(rot_mode_i);

  // Two searchers: fixed base 0, and rotating base = pointer.
  dma_prio_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick_fix (
    .req_i(req_i), .base_i('0),
    .onehot_o(oh_fix), .idx_o(idx_fix), .found_o(fnd_fix)
  );

  dma_prio_pick #(.N_CH(N_CH), .IDX_W(IDX_W)) u_pick_rot (
    .req_i(req_i), .base_i(ptr_q),
    .onehot_o(oh_rot), .idx_o(idx_rot), .found_o(fnd_rot)
  );

  assign gnt_d = (mode == PRIO_ROTATE) ? oh_rot : oh_fix;
  // Pointer moves only on an issued rotating grant.
  assign adv   = arb_strobe_i && (mode == PRIO_ROTATE) && fnd_rot;

  dma_prio_ptr #(.N_CH(N_CH), .IDX_W(IDX_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv), .idx_i(idx_rot), .ptr_o(ptr_q)
  );

  dma_prio_gnt_reg #(.N_CH(N_CH)) u_gnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(arb_strobe_i),
    .gnt_d_i(gnt_d), .gnt_o(gnt_o), .valid_o(gnt_valid_o)
  );

  logic unused_fix;
  assign unused_fix = fnd_fix ^ (^idx_fix);
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] req_i,
  input logic            rot_mode_i,
  input logic            arb_strobe_i,
  input logic [N_CH-1:0] gnt_o,
  input logic            gnt_valid_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R8

  AST_VALID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o == (gnt_o != '0)); // R8

  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arb_strobe_i |=> ($stable(gnt_o) && $stable(gnt_valid_o))); // R7

  AST_GNT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_strobe_i && req_i != '0) |=> (gnt_valid_o && ((gnt_o & $past(req_i)) != '0))); // R9

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_strobe_i && req_i == '0) |=> !gnt_valid_o); // R2

  AST_FIXED_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_strobe_i && !rot_mode_i && req_i[0]) |=> gnt_o[0]); // R3
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rot_mode_i(rot_mode_i),
  .arb_strobe_i(arb_strobe_i), .gnt_o(gnt_o), .gnt_valid_o(gnt_valid_o)
);

// File: tb/dma_prio_arb_tb.sv
module dma_prio_arb_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req = '0;
  logic       mode = 1'b0;
  logic       strobe = 1'b0;
  logic [3:0] gnt;
  logic       gnt_valid;

  int checks = 0;
  int errors = 0;

  // reference model state
  int         m_ptr = 0;
  logic [3:0] exp_g = '0;
  logic       exp_v = 1'b0;
  logic [3:0] strobe_req = '0;
  string      pend_tag = "R1";

  always #2 clk = ~clk;

  dma_prio_arb u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .rot_mode_i(mode),
    .arb_strobe_i(strobe), .gnt_o(gnt), .gnt_valid_o(gnt_valid)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic compare();
    check(pend_tag, gnt, exp_g);
    check("R8", {3'b0, gnt_valid}, {3'b0, exp_v});
    if (gnt_valid) check("R9", {3'b0, (gnt & strobe_req) != 0}, 4'b0001);
  endtask

  // Compare previous outcome, then apply new inputs and predict the next edge.
  task automatic step(input logic [3:0] r, input logic m, input logic s, input string tag);
    int base;
    int win;
    @(negedge clk);
    compare();
    req = r; mode = m; strobe = s;
    pend_tag = tag;
    if (s) begin
      strobe_req = r;
      if (r == 0) begin
        exp_g = '0; exp_v = 1'b0;
      end else begin
        base = m ? m_ptr : 0;
        win = -1;
        for (int k = 0; k < 4; k++) begin
          int c;
          c = (base + k) % 4;
          if (win < 0 && r[c]) win = c;
        end
        exp_g = 4'(1 << win); exp_v = 1'b1;
        if (m) m_ptr = (win + 1) % 4;
      end
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1", gnt, 4'b0000);
    check("R1", {3'b0, gnt_valid}, 4'b0000);
    // toggle inputs during reset: must have no effect
    req = 4'hF; strobe = 1'b1; mode = 1'b1;
    @(negedge clk);
    check("R1", gnt, 4'b0000);
    req = '0; strobe = 1'b0; mode = 1'b0;
    rst_ni = 1'b1;

    // R1: first rotating grant after reset goes to channel 0
    step(4'hF, 1, 1, "R1");
    // R5: back-to-back rotating strobes walk 1,2,3 then wrap to 0
    step(4'hF, 1, 1, "R5");
    step(4'hF, 1, 1, "R5");
    step(4'hF, 1, 1, "R5");
    step(4'hF, 1, 1, "R5");
    // R4: partial requests search upward with wrap
    step(4'b1001, 1, 1, "R4");   // ptr1 -> ch3
    step(4'b0011, 1, 1, "R4");   // ptr0 -> ch0
    step(4'b0101, 1, 1, "R4");   // ptr1 -> ch2
    // R7: grant held while strobe low and requests change
    step(4'b0000, 1, 0, "R7");
    step(4'b1111, 0, 0, "R7");
    step(4'b0001, 1, 0, "R7");
    // R2 / R6: idle strobe clears grant, pointer kept (ptr=3)
    step(4'b0000, 1, 1, "R2");
    step(4'hF, 1, 1, "R6");      // ch3
    // R3 / R6 / R10: fixed-mode grants do not move pointer (ptr=0)
    step(4'b1110, 0, 1, "R3");   // ch1
    step(4'b1100, 0, 1, "R3");   // ch2
    step(4'b1000, 0, 1, "R3");   // ch3
    step(4'b1111, 0, 1, "R3");   // ch0
    step(4'b1110, 1, 1, "R10");  // rotating from ptr0 -> ch1
    step(4'b1111, 0, 1, "R10");  // fixed -> ch0
    step(4'b1111, 1, 1, "R10");  // rotating from ptr2 -> ch2
    step(4'b0000, 1, 0, "R7");

    // Mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      logic [3:0] r;
      logic m, s;
      string t;
      r = 4'($urandom_range(0, 15));
      m = 1'($urandom_range(0, 1));
      s = ($urandom_range(0, 2) == 0);
      if (!s)         t = "R7";
      else if (r == 0) t = "R2";
      else if (m)     t = "R4";
      else            t = "R3";
      step(r, m, s, t);
    end
    step(4'b0000, 0, 0, "R7");
    @(negedge clk);
    compare();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule